// File: doc/BRIEF.md
# Data Bus Grant Qualifier

This block sits on the master side of a bus whose address and data phases are split and may be pipelined. It watches the master's own transfer-start strobes and uses them in place of a data request. A transfer that is not address-only leaves behind a pending data tenure. The block tracks each pending data tenure against the address tenure that created it. It decides the cycle in which the master may take the data bus, and it drives the master's busy indication while it holds that bus.

Pending tenures wait in a two-slot in-order queue. The block follows each slot through its address phase. A retry is charged to the oldest address tenure whose retry window is open. That window starts in the second cycle after the strobe and ends in the cycle right after the address acknowledge. A retry charged to an address tenure removes that tenure. Only the slot at the head of the queue can receive a grant. A retry that lands on a younger, pipelined tenure therefore does not hold back the head.

Top module: `dbq_grant_qualifier`

## Requirements
- R1: A synchronous active-high reset empties the queue. In the cycle after reset, `qual_grant_o`, `data_start_o` and `dbb_o` are all low.
- R2: `qual_grant_o` is high in a cycle only if `dbg_i` is high, `dbb_i` is low and `dbb_o` is low in that cycle, and no retry is charged to the head tenure in that cycle. It is a combinational pulse within that cycle.
- R3: When no data tenure is pending, `dbg_i` has no effect and `qual_grant_o` stays low. A strobe with `addr_only_i` high creates no data tenure.
- R4: `artry_i` is charged to the oldest tenure whose window is open. If the charge lands on the head, the head is removed and any grant in that cycle is dropped. If it lands on a younger tenure, the head can still be granted in that cycle.
- R5: A tenure's retry window runs from the second cycle after its strobe up to and including the cycle after its `aack_i`. `artry_i` in the first cycle after the strobe has no effect on that tenure. From the second cycle after `aack_i` onward, `artry_i` also has no effect on it.
- R6: While `dbg_i` is low, the pending head is held without any time limit. It is granted in the first cycle in which all the conditions are met.
- R7: A grant in cycle c raises `data_start_o` for exactly cycle c+1. `dbb_o` is high from c+1 until the cycle after `data_done_i`. No grant is issued while `dbb_o` is high.
- R8: Data tenures are granted in the order of their strobes. The queue holds two tenures.
- R9: The head becomes eligible only in the cycle after its `aack_i`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ts_i | input | 1 | Transfer-start strobe of this master |
| addr_only_i | input | 1 | The strobed transfer has no data phase |
| aack_i | input | 1 | Address acknowledge |
| artry_i | input | 1 | Address retry |
| dbg_i | input | 1 | Data bus grant from the arbiter |
| dbb_i | input | 1 | Data bus busy from other masters |
| data_done_i | input | 1 | Last cycle of this master's data tenure |
| qual_grant_o | output | 1 | Qualified grant, valid within the current cycle |
| data_start_o | output | 1 | One-cycle pulse at the start of the data tenure |
| dbb_o | output | 1 | This master owns the data bus |

## Verification
Within each cycle, `qual_grant_o` is a combinational function of that cycle's inputs. `data_start_o` and `dbb_o` change one register later, and `dbb_o` falls one cycle after `data_done_i`. A strobe in cycle 0 reaches the head's state in cycle 1. Retry charging becomes possible in cycle 2. An acknowledge in cycle d makes the head eligible in cycle d+1. The bench drives each cycle's inputs on the falling edge and compares all three outputs shortly afterwards. It compares the grant against the inputs of the same cycle, and the registered outputs against the state left by the preceding rising edge. The expected grant cycle is computed as max(d+1, g). Here d is the acknowledge delay and g is the cycle in which the grant input rises.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_ACKED = 2'd1,
        PH_CLEAR = 2'd2
    } phase_e;

    typedef struct packed {
        logic   valid;
        logic   has_data;
        logic   aged;
        phase_e phase;
    } slot_t;

endpackage

// File: rtl/dbq_tenure_queue.sv
module dbq_tenure_queue
    import dbq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ts_i,
    input  logic addr_only_i,
    input  logic aack_i,
    input  logic artry_i,
    input  logic pop_i,
    output logic head_ready_o,
    output logic head_retry_o
);
    localparam int IW = $clog2(DEPTH + 1);

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } q_state_t;

    q_state_t q_d, q_q;
    logic [DEPTH-1:0] ack_hit, retry_hit;
    logic ack_found, retry_found;
    logic [IW-1:0] wr;
    slot_t s;

    always_comb begin
        ack_hit     = '0;
        retry_hit   = '0;
        ack_found   = 1'b0;
        retry_found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ack_found && q_q.slot[i].valid && q_q.slot[i].phase == PH_WAIT) begin
                ack_hit[i] = aack_i;
                ack_found  = 1'b1;
            end
            if (!retry_found && q_q.slot[i].valid &&
                ((q_q.slot[i].phase == PH_WAIT && q_q.slot[i].aged) ||
                 q_q.slot[i].phase == PH_ACKED)) begin
                retry_hit[i] = artry_i;
                retry_found  = 1'b1;
            end
        end

        head_ready_o = q_q.slot[0].valid && q_q.slot[0].has_data &&
                       q_q.slot[0].phase != PH_WAIT;
        head_retry_o = retry_hit[0];

        q_d = '0;
        wr  = '0;
        s   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s = q_q.slot[i];
            if (s.valid && !retry_hit[i] && !(i == 0 && pop_i) &&
                !(!s.has_data && s.phase == PH_CLEAR)) begin
                if (s.phase == PH_WAIT) begin
                    s.aged = 1'b1;
                    if (ack_hit[i]) s.phase = PH_ACKED;
                end else if (s.phase == PH_ACKED) begin
                    s.phase = PH_CLEAR;
                end
                q_d.slot[wr] = s;
                wr = wr + 1'b1;
            end
        end
        if (ts_i && wr < IW'(DEPTH)) begin
            q_d.slot[wr] = '{valid: 1'b1, has_data: !addr_only_i,
                             aged: 1'b0, phase: PH_WAIT};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

endmodule

// File: rtl/dbq_data_owner.sv
module dbq_data_owner (
    input  logic clk,
    input  logic rst,
    input  logic head_ready_i,
    input  logic head_retry_i,
    input  logic dbg_i,
    input  logic dbb_i,
    input  logic done_i,
    output logic qual_grant_o,
    output logic data_start_o,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
        logic start;
    } own_t;

    own_t own_d, own_q;
    logic qual;

    always_comb begin
        qual = head_ready_i && !head_retry_i && dbg_i && !dbb_i && !own_q.busy;
        own_d.start = qual;
        own_d.busy  = qual || (own_q.busy && !done_i);
    end

    always_ff @(posedge clk) begin
        if (rst) own_q <= '0;
        else     own_q <= own_d;
    end

    assign qual_grant_o = qual;
    assign data_start_o = own_q.start;
    assign busy_o       = own_q.busy;

endmodule

// File: rtl/dbq_grant_qualifier.sv
module dbq_grant_qualifier #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ts_i,
    input  logic addr_only_i,
    input  logic aack_i,
    input  logic artry_i,
    input  logic dbg_i,
    input  logic dbb_i,
    input  logic data_done_i,
    output logic qual_grant_o,
    output logic data_start_o,
    output logic dbb_o
);
    logic head_ready, head_retry, grant;

    dbq_tenure_queue #(.DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .ts_i         (ts_i),
        .addr_only_i  (addr_only_i),
        .aack_i       (aack_i),
        .artry_i      (artry_i),
        .pop_i        (grant),
        .head_ready_o (head_ready),
        .head_retry_o (head_retry)
    );

    dbq_data_owner u_owner (
        .clk          (clk),
        .rst          (rst),
        .head_ready_i (head_ready),
        .head_retry_i (head_retry),
        .dbg_i        (dbg_i),
        .dbb_i        (dbb_i),
        .done_i       (data_done_i),
        .qual_grant_o (grant),
        .data_start_o (data_start_o),
        .busy_o       (dbb_o)
    );

    assign qual_grant_o = grant;

endmodule

// File: rtl/dbq_grant_qualifier_chk.sv
module dbq_grant_qualifier_chk (
    input logic clk,
    input logic rst,
    input logic dbg_i,
    input logic dbb_i,
    input logic data_done_i,
    input logic qual_grant_o,
    input logic data_start_o,
    input logic dbb_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!dbb_o && !data_start_o));

    p_grant_inputs_r2: assert property (@(posedge clk) disable iff (rst)
        qual_grant_o |-> (dbg_i && !dbb_i && !dbb_o));

    p_start_after_grant_r7: assert property (@(posedge clk) disable iff (rst)
        qual_grant_o |=> (data_start_o && dbb_o));

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (dbb_o && !data_done_i) |=> dbb_o);

    p_busy_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (dbb_o && data_done_i) |=> !dbb_o);

    p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
        data_start_o |=> !data_start_o);

endmodule

bind dbq_grant_qualifier dbq_grant_qualifier_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dbg_i        (dbg_i),
    .dbb_i        (dbb_i),
    .data_done_i  (data_done_i),
    .qual_grant_o (qual_grant_o),
    .data_start_o (data_start_o),
    .dbb_o        (dbb_o)
);

// File: tb/dbq_grant_qualifier_bench.sv
module dbq_grant_qualifier_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ts = 1'b0, ao = 1'b0, aack = 1'b0, artry = 1'b0;
    logic dbg = 1'b0, dbb_in = 1'b0, done = 1'b0;
    logic qual, start, busy;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dbq_grant_qualifier u_dbq_grant_qualifier (
        .clk          (clk),
        .rst          (rst),
        .ts_i         (ts),
        .addr_only_i  (ao),
        .aack_i       (aack),
        .artry_i      (artry),
        .dbg_i        (dbg),
        .dbb_i        (dbb_in),
        .data_done_i  (done),
        .qual_grant_o (qual),
        .data_start_o (start),
        .dbb_o        (busy)
    );

    task automatic cmp(input logic eq, input logic es, input logic eb, input string tag);
        n_cmp++;
        if ({qual, start, busy} !== {eq, es, eb}) begin
            n_bad++;
            $display("FAIL %s t=%0t qual/start/busy actual=%b%b%b expected=%b%b%b",
                     tag, $time, qual, start, busy, eq, es, eb);
        end
    endtask

    task automatic step(input logic t, input logic a_o, input logic ak, input logic rt,
                        input logic g, input logic bb, input logic dn,
                        input logic eq, input logic es, input logic eb, input string tag);
        @(negedge clk);
        ts = t; ao = a_o; aack = ak; artry = rt; dbg = g; dbb_in = bb; done = dn;
        #1 cmp(eq, es, eb, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ts = 0; ao = 0; aack = 0; artry = 0; dbg = 0; dbb_in = 0; done = 0;
        @(negedge clk);
        rst = 1'b0;
        #1 cmp(1'b0, 1'b0, 1'b0, "R1 reset");
    endtask

    // one tenure: ack delay d, retry at cycle r (0 = none), grant high from cycle g
    task automatic run_single(input int d, input int r, input int g);
        bit retried = (r >= 2) && (r <= d + 1);
        int c = (d + 1 > g) ? d + 1 : g;
        do_reset();
        for (int k = 0; k < 12; k++) begin
            logic eq = !retried && (k == c);
            logic es = !retried && (k == c + 1);
            logic eb = !retried && (k >= c + 1) && (k <= c + 2);
            step(k == 0, 1'b0, k == d, (r != 0) && (k == r), k >= g, 1'b0,
                 !retried && (k == c + 2), eq, es, eb, "R2 R4 R5 R7 R9 sweep");
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset, then sweep of single-tenure timing
        for (int d = 1; d <= 4; d++)
            for (int r = 0; r <= d + 3; r++)
                for (int g = 0; g <= 6; g++)
                    run_single(d, r, g);

        // R3: grant with nothing pending, and an address-only transfer
        do_reset();
        for (int k = 0; k < 10; k++)
            step(k == 2, k == 2, k == 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                 "R3 no data tenure");

        // R2: other master busy holds off the grant until it drops
        do_reset();
        for (int k = 0; k < 8; k++)
            step(k == 0, 1'b0, k == 1, 1'b0, 1'b1, k <= 3, k == 6,
                 k == 4, k == 5, (k >= 5) && (k <= 6), "R2 dbb_i blocks");

        // R6: grant low for a long stretch
        do_reset();
        for (int k = 0; k < 64; k++)
            step(k == 0, 1'b0, k == 1, 1'b0, k >= 60, 1'b0, k == 62,
                 k == 60, k == 61, (k >= 61) && (k <= 62), "R6 hold-off");

        // R4: retry charged to younger tenure does not block the head
        do_reset();
        for (int k = 0; k < 13; k++)
            step(k <= 1, 1'b0, (k == 2) || (k == 3), k == 4, k >= 4, 1'b0, k == 6,
                 k == 4, k == 5, (k >= 5) && (k <= 6), "R4 younger retried");

        // R4: retry charged to head removes it, younger tenure granted later
        do_reset();
        for (int k = 0; k < 9; k++)
            step(k <= 1, 1'b0, (k == 1) || (k == 3), k == 2, k >= 2, 1'b0, k == 6,
                 k == 4, k == 5, (k >= 5) && (k <= 6), "R4 head retried");

        // R8: two pipelined tenures granted in order; R7 no grant while busy
        do_reset();
        for (int k = 0; k < 10; k++)
            step(k <= 1, 1'b0, (k == 1) || (k == 2), 1'b0, 1'b1, 1'b0,
                 (k == 3) || (k == 6),
                 (k == 2) || (k == 4), (k == 3) || (k == 5),
                 (k == 3) || (k == 5) || (k == 6), "R8 in-order R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule